// File: doc/BRIEF.md
# Quarter-Wave Folded DDS Sine Generator

This block makes a stream of signed sine samples by direct digital synthesis. A 24-bit phase accumulator advances by a frequency word on every clock. The output frequency is freq_word × f_clk / 2^24. A phase offset word is added to the upper accumulator bits, which gives a 13-bit lookup address. Only the first quarter of a sine period is stored, in a 2048-entry table of 8-bit magnitudes. The second address bit from the top reads that table backwards. The top bit gives the sample a negative sign. Together these rebuild the full period.

The table is computed when the design elaborates; it is not loaded from a file. An active-low enable starts and stops generation. While generation is stopped, the phase returns to zero and the output rests at zero. The first sample after enabling therefore always comes from the address equal to the phase word, so the phase word sets the starting phase.

A small two-state controller handles enabling. In state IDLE (enable high) the accumulator is cleared. The transition GO (enable driven low) moves it to RUN, where the accumulator steps every clock. The transition HALT (enable driven high) returns it to IDLE. Both transitions act on the edge at which the enable level is sampled.

Top module: `quarter_dds_gen`

## Requirements
- R1: While enabled, the 24-bit phase accumulator adds the 9-bit frequency word on each rising clock edge and wraps modulo 2^24.
- R2: The lookup address is (accumulator bits 23..11) + phase word (11 bits, zero-extended), modulo 2^13.
- R3: Table entry i (0..2047) holds the magnitude round(255·sin(π·i/4096)), within 1 LSB. When address bits 12..11 are 00, the sample is +table[address bits 10..0].
- R4: When address bit 11 is 1, the table index is the bitwise inverse of address bits 10..0, i.e. 2047 minus those bits.
- R5: When address bit 12 is 1, the sample is the two's-complement negative of the table magnitude.
- R6: The output is a 9-bit two's-complement sample. It is registered with one cycle of latency: the value after an edge comes from the address formed by the accumulator value and phase word present before that edge.
- R7: While en_n is high at an edge (state IDLE), the accumulator is cleared and the sample after that edge is 0. The first edge with en_n low (transition GO) yields the sample at address equal to the phase word. Synchronous reset also clears the accumulator and the output.
- R8: When the phase offset carries the address past 8191, the address wraps to the start of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low generation enable |
| freq_word | input | 9 | Phase step added each clock |
| phase_word | input | 11 | Phase offset added at address level |
| sample | output | 9 | Signed sine sample, two's complement |

## Verification
The bench sweeps whole periods at the largest frequency word. This exercises every quadrant boundary. A design that mirrors the wrong half, or mirrors with an off-by-one index, shows jumps of tens of LSBs at the π/2 and 3π/2 seams. Runs with a large phase offset force the address adder to wrap past 8191. A design that kept the carry, or added the offset to the accumulator at the wrong bit position, would drift out of phase there. The bench also toggles the enable in the middle of a run. A design that kept the stale phase, or whose sign pipeline ran one cycle ahead of the table data, would either produce the wrong first sample or flip the polarity on the cycle after a π crossing.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int ACC_W   = 24;
    localparam int FREQ_W  = 9;
    localparam int PHASE_W = 11;
    localparam int ADDR_W  = 13;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int MAG_W   = 8;
    localparam int OUT_W   = MAG_W + 1;
    localparam int ENTRIES = 1 << IDX_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dds_state_e;

    // pi scaled by 2^30, rounded
    localparam longint PI_Q30 = 64'sd3373259426;

    // Magnitude of sin(pi/2 * idx / ENTRIES) scaled to full MAG_W range.
    // Fixed-point Taylor series in Q30, evaluated during elaboration.
    function automatic logic [MAG_W-1:0] quarter_sine(input int idx);
        longint x;
        longint x2;
        longint term;
        longint sum;
        longint scaled;
        longint full;
        full   = (64'sd1 << MAG_W) - 64'sd1;
        x      = (longint'(idx) * PI_Q30) / longint'(2 * ENTRIES);
        x2     = (x * x) >>> 30;
        term   = x;
        sum    = x;
        for (int k = 1; k <= 6; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        scaled = (sum * full + (64'sd1 <<< 29)) >>> 30;
        if (scaled < 0) scaled = 0;
        if (scaled > full) scaled = full;
        return scaled[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
    import dds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    output logic run,
    output logic clear
);

    dds_state_e state_q;
    dds_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        clear   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (!en_n) begin          // GO
                    state_d = ST_RUN;
                    run     = 1'b1;
                    clear   = 1'b0;
                end
            end
            ST_RUN: begin
                if (en_n) begin           // HALT
                    state_d = ST_IDLE;
                end else begin
                    run   = 1'b1;
                    clear = 1'b0;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // R7: a high enable always lands the controller in IDLE
    p_idle_on_high_r7: assert property (@(posedge clk) disable iff (rst)
        en_n |=> state_q == ST_IDLE);

    p_run_on_low_r7: assert property (@(posedge clk) disable iff (rst)
        !en_n |=> state_q == ST_RUN);

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int FW = FREQ_W,
    parameter int PW = PHASE_W,
    parameter int DW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [FW-1:0] freq_word,
    input  logic [PW-1:0] phase_word,
    output logic [DW-1:0] addr
);

    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= acc_q + AW'(freq_word);
        end
    end

    // offset added at address width so the sum wraps modulo 2^DW
    always_comb begin
        addr = acc_q[AW-1 -: DW] + DW'(phase_word);
    end

    // R1: a running accumulator advances by exactly the frequency word
    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        run |=> acc_q == $past(acc_q) + AW'($past(freq_word)));

    // R7: a clear leaves the accumulator at zero
    p_acc_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc_q == '0);

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom
    import dds_pkg::*;
#(
    parameter int DW = ADDR_W,
    parameter int MW = MAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [DW-1:0] addr,
    output logic [MW-1:0] mag_q,
    output logic          neg_q
);

    localparam int IW    = DW - 2;
    localparam int DEPTH = 1 << IW;

    logic [MW-1:0] table_w [DEPTH];
    logic [IW-1:0] idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        localparam logic [MW-1:0] ENTRY = quarter_sine(g);
        assign table_w[g] = ENTRY;
    end

    // second quadrant and fourth quadrant read the quarter wave backwards
    always_comb begin
        if (addr[DW-2]) begin
            idx = ~addr[IW-1:0];
        end else begin
            idx = addr[IW-1:0];
        end
    end

    // registered read; sign travels with the data
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mag_q <= table_w[idx];
            neg_q <= addr[DW-1];
        end
    end

    // R5: sign flag follows the top address bit one cycle later
    p_sign_align_r5: assert property (@(posedge clk) disable iff (rst)
        !clear |=> neg_q == $past(addr[DW-1]));

    // R7: idle clears the data path
    p_rom_zero_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (mag_q == '0) && !neg_q);

endmodule

// File: rtl/quarter_dds_gen.sv
module quarter_dds_gen
    import dds_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en_n,
    input  logic [FREQ_W-1:0]   freq_word,
    input  logic [PHASE_W-1:0]  phase_word,
    output logic [OUT_W-1:0]    sample
);

    logic              run;
    logic              clear;
    logic [ADDR_W-1:0] addr;
    logic [MAG_W-1:0]  mag_q;
    logic              neg_q;
    logic [OUT_W-1:0]  mag_ext;

    dds_ctrl i_ctrl (
        .clk   (clk),
        .rst   (rst),
        .en_n  (en_n),
        .run   (run),
        .clear (clear)
    );

    dds_phase_acc #(
        .AW (ACC_W),
        .FW (FREQ_W),
        .PW (PHASE_W),
        .DW (ADDR_W)
    ) i_acc (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .clear      (clear),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .addr       (addr)
    );

    dds_quarter_rom #(
        .DW (ADDR_W),
        .MW (MAG_W)
    ) i_rom (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .addr  (addr),
        .mag_q (mag_q),
        .neg_q (neg_q)
    );

    always_comb begin
        mag_ext = {1'b0, mag_q};
        sample  = neg_q ? (~mag_ext + 1'b1) : mag_ext;
    end

    // R7: a high enable yields a zero sample on the next cycle
    p_out_zero_r7: assert property (@(posedge clk) disable iff (rst)
        en_n |=> sample == '0);

    // R3: first half of the period never gives a negative sample
    p_pos_half_r3: assert property (@(posedge clk) disable iff (rst)
        (!en_n && !addr[ADDR_W-1]) |=> !sample[OUT_W-1]);

    // R5: second half never gives a positive sample
    p_neg_half_r5: assert property (@(posedge clk) disable iff (rst)
        (!en_n && addr[ADDR_W-1]) |=> (sample[OUT_W-1] || sample == '0));

    // R6: magnitude stays within the table range
    p_range_r6: assert property (@(posedge clk) disable iff (rst)
        sample != {1'b1, {(OUT_W-1){1'b0}}});

endmodule

// File: tb/test_quarter_dds_gen.sv
module test_quarter_dds_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b1;
    logic [8:0] freq_word = '0;
    logic [10:0] phase_word = '0;
    logic [8:0] sample;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int    m_acc = 0;
    int    m_exp = 0;
    string m_tag = "R7";
    bit    m_first = 1'b0;
    bit    m_prev_en = 1'b0;

    always #4 clk = ~clk;

    quarter_dds_gen i_quarter_dds_gen (
        .clk        (clk),
        .rst        (rst),
        .en_n       (en_n),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .sample     (sample)
    );

    function automatic int ref_sample(int a);
        int q;
        int i;
        int m;
        q = a / 2048;
        i = a % 2048;
        if (q % 2 == 1) i = 2047 - i;
        m = $rtoi(255.0 * $sin(3.14159265358979 * i / 4096.0) + 0.5);
        return (q >= 2) ? -m : m;
    endfunction

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        int addr;
        int sum;
        if (rst || en_n) begin
            m_acc     = 0;
            m_exp     = 0;
            m_tag     = "R7";
            m_first   = 1'b0;
            m_prev_en = 1'b0;
        end else begin
            sum  = (m_acc / 2048) + phase_word;
            addr = sum % 8192;
            m_exp = ref_sample(addr);
            if (!m_prev_en)          m_tag = "R7";
            else if (sum >= 8192)    m_tag = "R8";
            else if (addr >= 4096)   m_tag = "R5";
            else if (addr >= 2048)   m_tag = "R4";
            else                     m_tag = "R3";
            m_first   = !m_prev_en;
            m_prev_en = 1'b1;
            if (m_acc + freq_word >= (1 << 24)) m_tag = "R1";
            m_acc = (m_acc + freq_word) % (1 << 24);
        end
    end

    // compare every cycle, away from the active edge (R2, R6 on all samples)
    always @(negedge clk) begin
        int act;
        int diff;
        if (!done) begin
            act  = int'($signed(sample));
            diff = act - m_exp;
            checks++;
            if (diff > 1 || diff < -1) begin
                errors++;
                $display("FAIL %s (R2/R6) t=%0t actual=%0d expected=%0d",
                         m_tag, $time, act, m_exp);
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_first(int ph);
        int act;
        int want;
        want = ref_sample(ph);
        act  = int'($signed(sample));
        checks++;
        if (act - want > 1 || want - act > 1) begin
            errors++;
            $display("FAIL R7 first sample actual=%0d expected=%0d", act, want);
        end
    endtask

    initial begin
        cycles(4);
        checks++;
        if (sample !== 9'd0) begin
            errors++;
            $display("FAIL R7 reset actual=%0d expected=0", $signed(sample));
        end
        rst = 1'b0;
        cycles(3);

        // R7: the classic start-up case, address 180 first
        freq_word  = 9'd50;
        phase_word = 11'd180;
        en_n       = 1'b0;
        cycles(1);
        expect_first(180);
        cycles(40);

        // R1 R3 R4 R5: whole periods at the largest step
        freq_word  = 9'd511;
        phase_word = 11'd0;
        cycles(34000);

        // R7: halt then restart with a new phase
        en_n = 1'b1;
        cycles(5);
        phase_word = 11'd2047;
        freq_word  = 9'd511;
        en_n       = 1'b0;
        cycles(1);
        expect_first(2047);

        // R8: large offset wraps the address
        phase_word = 11'd1500;
        cycles(34000);

        // R2: phase changes on the fly with a slow step
        freq_word = 9'd1;
        for (int k = 0; k < 8; k++) begin
            phase_word = 11'(k * 257);
            cycles(20);
        end

        en_n = 1'b1;
        cycles(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule